// File: doc/BRIEF.md
# Indirect Data Pointer Address Generator

This unit forms the data-space address for indirect loads and stores. Three 16-bit pointers, named X, Y and Z, are built from pairs of general registers outside the block and are presented to it as whole 16-bit values. On each accepted request the unit picks one pointer and applies one of four addressing modes: plain, post-increment, pre-decrement, or base plus an unsigned 6-bit displacement. It returns the effective address, the updated pointer value to write back, and the region of the linear data space that the address falls in.

The data space is a single linear map. The lowest 32 addresses reach the register file, the next 64 reach the I/O locations, and the next 128 reach the SRAM. Anything above that is flagged as out of range. For each hit the unit also gives the offset inside the region, so the memory that serves the access can index it directly. An indirect access takes two cycles. The request is captured on one edge, and the result is held valid for the following cycle. The unit accepts no new request during that cycle.

Top module: `ptr_agu`

## Requirements
- R1: After reset, addr_vld, wb_en and req_err are 0, and addr, region_off and wb_ptr are 0.
- R2: Pointer select codes are 0 = X, 1 = Y, 2 = Z. Code 3 is rejected. In plain mode (mode code 0), addr equals the selected pointer and wb_en stays 0.
- R3: In post-increment mode (mode code 1), addr is the pointer value and wb_ptr is the pointer plus 1 modulo 2^16, with wb_en = 1 and wb_sel equal to the select code.
- R4: In pre-decrement mode (mode code 2), the pointer minus 1 modulo 2^16 is both addr and wb_ptr, with wb_en = 1.
- R5: In displacement mode (mode code 3) on Y or Z, addr is the pointer plus the zero-extended disp, modulo 2^16, and wb_en stays 0.
- R6: Displacement mode on X, or any request with select code 3, gives req_err = 1 for one cycle. In that case addr_vld and wb_en stay 0 and addr, region and region_off keep their previous values.
- R7: An address in 0x0000–0x001F gives region code 0 (register file), with region_off equal to addr.
- R8: An address in 0x0020–0x005F gives region code 1 (I/O), with region_off = addr − 0x20.
- R9: An address in 0x0060–0x00DF gives region code 2 (SRAM), with region_off = addr − 0x60. A higher address gives region code 3 (out of range), with region_off = 0.
- R10: A request sampled with req = 1 on a clock edge shows its result after that edge. addr_vld (or req_err) is high for exactly one cycle. A req held high during that cycle is ignored and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| disp | input | 6 | Unsigned displacement |
| ptr_x | input | 16 | Current X pointer value |
| ptr_y | input | 16 | Current Y pointer value |
| ptr_z | input | 16 | Current Z pointer value |
| addr_vld | output | 1 | Result valid pulse |
| addr | output | 16 | Effective data address |
| region | output | 2 | 0 registers, 1 I/O, 2 SRAM, 3 out of range |
| region_off | output | 16 | Offset inside the region |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer to write back |
| wb_ptr | output | 16 | Updated pointer value |
| req_err | output | 1 | Illegal select or mode pulse |

## Verification
The assertions assume that req, ptr_sel, mode, disp and the pointer inputs are stable around the clock edge. They also assume that a request sampled while a result is showing is simply dropped, with no retry. The bench drives all inputs on the falling edge and samples the outputs on the next falling edge. It drops req for a cycle after every access, except in the directed case that holds req high on purpose to test the ignore rule. The random pointers are biased toward the low 256 addresses, with the wrap values 0x0000 and 0xFFFF added, so that every region boundary is reached.

// File: rtl/ptr_agu_pkg.sv
package ptr_agu_pkg;
   typedef enum logic [1:0] {PSEL_X = 2'd0, PSEL_Y = 2'd1, PSEL_Z = 2'd2, PSEL_RSV = 2'd3} psel_e;
   typedef enum logic [1:0] {AM_PLAIN = 2'd0, AM_POSTINC = 2'd1, AM_PREDEC = 2'd2, AM_DISP = 2'd3} amode_e;
   typedef enum logic [1:0] {RGN_REGS = 2'd0, RGN_IO = 2'd1, RGN_SRAM = 2'd2, RGN_NONE = 2'd3} rgn_e;
endpackage

// File: rtl/ptr_agu_sel.sv
module ptr_agu_sel #(
   parameter int AW = 16
) (
   input  logic [1:0]    sel,
   input  logic [AW-1:0] ptr_x,
   input  logic [AW-1:0] ptr_y,
   input  logic [AW-1:0] ptr_z,
   output logic [AW-1:0] base,
   output logic          sel_bad,
   output logic          disp_ok
);
   import ptr_agu_pkg::*;

   always_comb begin
      base    = '0;
      sel_bad = 1'b0;
      disp_ok = 1'b0;
      unique case (psel_e'(sel))
         PSEL_X:   base = ptr_x;
         PSEL_Y:   begin base = ptr_y; disp_ok = 1'b1; end
         PSEL_Z:   begin base = ptr_z; disp_ok = 1'b1; end
         default:  sel_bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/ptr_agu_ea.sv
module ptr_agu_ea #(
   parameter int AW = 16,
   parameter int QW = 6
) (
   input  logic [AW-1:0] base,
   input  logic [1:0]    mode,
   input  logic [QW-1:0] disp,
   input  logic          disp_ok,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] nxt,
   output logic          upd,
   output logic          mode_bad
);
   import ptr_agu_pkg::*;

   logic [AW-1:0] q_ext;
   logic [AW-1:0] inc_v;
   logic [AW-1:0] dec_v;

   assign q_ext = {{(AW-QW){1'b0}}, disp};
   assign inc_v = base + AW'(1);
   assign dec_v = base - AW'(1);

   always_comb begin
      ea       = base;
      nxt      = base;
      upd      = 1'b0;
      mode_bad = 1'b0;
      unique case (amode_e'(mode))
         AM_PLAIN:   ea = base;
         AM_POSTINC: begin ea = base;  nxt = inc_v; upd = 1'b1; end
         AM_PREDEC:  begin ea = dec_v; nxt = dec_v; upd = 1'b1; end
         default: begin
            ea       = base + q_ext;
            mode_bad = !disp_ok;
         end
      endcase
   end
endmodule

// File: rtl/ptr_agu_rgn.sv
module ptr_agu_rgn #(
   parameter int AW       = 16,
   parameter int REG_CNT  = 32,
   parameter int IO_CNT   = 64,
   parameter int SRAM_CNT = 128
) (
   input  logic [AW-1:0] ea,
   output logic [1:0]    region,
   output logic [AW-1:0] off
);
   import ptr_agu_pkg::*;

   localparam logic [AW-1:0] IO_BASE   = AW'(REG_CNT);
   localparam logic [AW-1:0] SRAM_BASE = AW'(REG_CNT + IO_CNT);

   logic          sram_hit;
   logic [AW-1:0] sram_off;

   generate
      if (SRAM_CNT > 0) begin : g_sram
         localparam logic [AW-1:0] SRAM_LAST = AW'(REG_CNT + IO_CNT + SRAM_CNT - 1);
         assign sram_hit = (ea >= SRAM_BASE) && (ea <= SRAM_LAST);
         assign sram_off = ea - SRAM_BASE;
      end else begin : g_nosram
         assign sram_hit = 1'b0;
         assign sram_off = '0;
      end
   endgenerate

   always_comb begin
      region = RGN_NONE;
      off    = '0;
      if (ea < IO_BASE) begin
         region = RGN_REGS;
         off    = ea;
      end else if (ea < SRAM_BASE) begin
         region = RGN_IO;
         off    = ea - IO_BASE;
      end else if (sram_hit) begin
         region = RGN_SRAM;
         off    = sram_off;
      end
   end
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu #(
   parameter int AW       = 16,
   parameter int QW       = 6,
   parameter int REG_CNT  = 32,
   parameter int IO_CNT   = 64,
   parameter int SRAM_CNT = 128
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [1:0]    ptr_sel,
   input  logic [1:0]    mode,
   input  logic [QW-1:0] disp,
   input  logic [AW-1:0] ptr_x,
   input  logic [AW-1:0] ptr_y,
   input  logic [AW-1:0] ptr_z,
   output logic          addr_vld,
   output logic [AW-1:0] addr,
   output logic [1:0]    region,
   output logic [AW-1:0] region_off,
   output logic          wb_en,
   output logic [1:0]    wb_sel,
   output logic [AW-1:0] wb_ptr,
   output logic          req_err
);
   import ptr_agu_pkg::*;

   localparam int            SPACE_END = REG_CNT + IO_CNT + SRAM_CNT;
   localparam logic [AW-1:0] IO_BASE   = AW'(REG_CNT);
   localparam logic [AW-1:0] SRAM_BASE = AW'(REG_CNT + IO_CNT);

   generate
      if (QW < 1 || QW >= AW) begin : g_bad_qw
         $error("ptr_agu: displacement width must be 1..AW-1");
      end
      if (REG_CNT < 1 || IO_CNT < 1 || SRAM_CNT < 0) begin : g_bad_cnt
         $error("ptr_agu: region sizes out of range");
      end
      if (AW < 31 && SPACE_END > (1 << AW)) begin : g_bad_space
         $error("ptr_agu: regions do not fit the address width");
      end
   endgenerate

   logic [AW-1:0] base, ea, nxt, off_c;
   logic          sel_bad, disp_ok, upd, mode_bad;
   logic [1:0]    rgn_c;

   ptr_agu_sel #(.AW(AW)) u_sel (
      .sel(ptr_sel), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
      .base(base), .sel_bad(sel_bad), .disp_ok(disp_ok)
   );

   ptr_agu_ea #(.AW(AW), .QW(QW)) u_ea (
      .base(base), .mode(mode), .disp(disp), .disp_ok(disp_ok),
      .ea(ea), .nxt(nxt), .upd(upd), .mode_bad(mode_bad)
   );

   ptr_agu_rgn #(.AW(AW), .REG_CNT(REG_CNT), .IO_CNT(IO_CNT), .SRAM_CNT(SRAM_CNT)) u_rgn (
      .ea(ea), .region(rgn_c), .off(off_c)
   );

   logic       taken_q;
   logic       accept;
   logic       bad;
   logic [1:0] mode_q;

   assign accept = req && !taken_q;
   assign bad    = sel_bad || mode_bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q    <= 1'b0;
         addr_vld   <= 1'b0;
         req_err    <= 1'b0;
         wb_en      <= 1'b0;
         addr       <= '0;
         region     <= RGN_REGS;
         region_off <= '0;
         wb_sel     <= '0;
         wb_ptr     <= '0;
         mode_q     <= AM_PLAIN;
      end else begin
         taken_q  <= accept;
         addr_vld <= accept && !bad;
         req_err  <= accept && bad;
         wb_en    <= accept && !bad && upd;
         if (accept && !bad) begin
            addr       <= ea;
            region     <= rgn_c;
            region_off <= off_c;
            wb_sel     <= ptr_sel;
            wb_ptr     <= nxt;
            mode_q     <= mode;
         end
      end
   end

   assert_slot_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      taken_q |=> !taken_q);
   assert_vld_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (!addr_vld && !wb_en));
   assert_wb_needs_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> addr_vld);
   assert_err_holds_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> $stable(addr));
   assert_postinc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && mode_q == AM_POSTINC) |-> (wb_ptr == addr + AW'(1)));
   assert_predec_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en && mode_q == AM_PREDEC) |-> (wb_ptr == addr));
   assert_regs_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && region == RGN_REGS) |-> (addr < IO_BASE && region_off == addr));
   assert_io_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && region == RGN_IO) |-> (addr >= IO_BASE && addr < SRAM_BASE));
   assert_sram_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && region == RGN_SRAM) |-> (region_off < AW'(SRAM_CNT)));
endmodule

// File: tb/ptr_agu_tb.sv
module ptr_agu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [1:0]  ptr_sel = '0;
   logic [1:0]  mode = '0;
   logic [5:0]  disp = '0;
   logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
   logic        addr_vld, wb_en, req_err;
   logic [15:0] addr, region_off, wb_ptr;
   logic [1:0]  region, wb_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] last_addr = '0;
   logic [15:0] last_off  = '0;
   logic [1:0]  last_rgn  = '0;

   always #4 clk = ~clk;

   ptr_agu u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .ptr_sel(ptr_sel), .mode(mode),
      .disp(disp), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
      .addr_vld(addr_vld), .addr(addr), .region(region), .region_off(region_off),
      .wb_en(wb_en), .wb_sel(wb_sel), .wb_ptr(wb_ptr), .req_err(req_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_rgn(input logic [15:0] a);
      if (a < 16'h20) return 2'd0;
      if (a < 16'h60) return 2'd1;
      if (a < 16'hE0) return 2'd2;
      return 2'd3;
   endfunction

   function automatic logic [15:0] exp_off(input logic [15:0] a);
      if (a < 16'h20) return a;
      if (a < 16'h60) return a - 16'h20;
      if (a < 16'hE0) return a - 16'h60;
      return 16'h0;
   endfunction

   function automatic logic [15:0] pick(input logic [1:0] s);
      return (s == 2'd0) ? ptr_x : (s == 2'd1) ? ptr_y : ptr_z;
   endfunction

   task automatic drive(input logic [1:0] s, input logic [1:0] m, input logic [5:0] q,
                        input logic [15:0] px, input logic [15:0] py, input logic [15:0] pz);
      ptr_sel = s; mode = m; disp = q; ptr_x = px; ptr_y = py; ptr_z = pz;
   endtask

   task automatic verify_outputs(input logic [1:0] s, input logic [1:0] m, input logic [5:0] q);
      logic [15:0] b, ea, nx;
      logic        bad_e, upd_e;
      b     = pick(s);
      bad_e = (s == 2'd3) || (m == 2'd3 && s == 2'd0);
      case (m)
         2'd1:    begin ea = b;         nx = b + 16'd1; upd_e = 1'b1; end
         2'd2:    begin ea = b - 16'd1; nx = ea;        upd_e = 1'b1; end
         2'd3:    begin ea = b + {10'd0, q}; nx = b;    upd_e = 1'b0; end
         default: begin ea = b;         nx = b;         upd_e = 1'b0; end
      endcase
      if (bad_e) begin
         check("R6 req_err", req_err, 1);
         check("R6 addr_vld low", addr_vld, 0);
         check("R6 wb_en low", wb_en, 0);
         check("R6 addr held", addr, last_addr);
         check("R6 region held", region, last_rgn);
      end else begin
         check("R10 addr_vld", addr_vld, 1);
         check("R10 req_err low", req_err, 0);
         case (m)
            2'd0: check("R2 plain addr", addr, ea);
            2'd1: check("R3 postinc addr", addr, ea);
            2'd2: check("R4 predec addr", addr, ea);
            default: check("R5 disp addr", addr, ea);
         endcase
         check(m == 2'd3 ? "R5 no write-back" : (m == 2'd0 ? "R2 no write-back" : "R3 write-back"),
               wb_en, upd_e);
         if (upd_e) begin
            check(m == 2'd1 ? "R3 wb_ptr" : "R4 wb_ptr", wb_ptr, nx);
            check("R3 wb_sel", wb_sel, s);
         end
         case (exp_rgn(ea))
            2'd0: begin check("R7 region", region, 0); check("R7 offset", region_off, exp_off(ea)); end
            2'd1: begin check("R8 region", region, 1); check("R8 offset", region_off, exp_off(ea)); end
            default: begin
               check("R9 region", region, exp_rgn(ea));
               check("R9 offset", region_off, exp_off(ea));
            end
         endcase
         last_addr = ea;
         last_rgn  = exp_rgn(ea);
         last_off  = exp_off(ea);
      end
   endtask

   task automatic do_op(input logic [1:0] s, input logic [1:0] m, input logic [5:0] q,
                        input logic [15:0] px, input logic [15:0] py, input logic [15:0] pz);
      @(negedge clk);
      drive(s, m, q, px, py, pz);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      verify_outputs(s, m, q);
   endtask

   function automatic logic [15:0] rnd_ptr();
      int k;
      k = $urandom % 10;
      if (k == 0) return 16'h0000;
      if (k == 1) return 16'hFFFF;
      if (k == 2) return 16'($urandom);
      return 16'($urandom % 256);
   endfunction

   initial begin
      #1_600_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(negedge clk);
      check("R1 addr_vld", addr_vld, 0);
      check("R1 wb_en", wb_en, 0);
      check("R1 req_err", req_err, 0);
      check("R1 addr", addr, 0);
      check("R1 region_off", region_off, 0);
      check("R1 wb_ptr", wb_ptr, 0);
      rst_n = 1'b1;

      // directed boundaries
      do_op(2'd0, 2'd0, 6'd0, 16'h001F, 16'h0, 16'h0);   // R7 top of register file
      do_op(2'd1, 2'd0, 6'd0, 16'h0, 16'h0020, 16'h0);   // R8 first I/O
      do_op(2'd2, 2'd0, 6'd0, 16'h0, 16'h0, 16'h005F);   // R8 last I/O
      do_op(2'd0, 2'd1, 6'd0, 16'h0060, 16'h0, 16'h0);   // R9 first SRAM
      do_op(2'd1, 2'd3, 6'd63, 16'h0, 16'h00A0, 16'h0);  // R5 last SRAM 0xDF
      do_op(2'd2, 2'd3, 6'd1, 16'h0, 16'h0, 16'h00DF);   // R9 0xE0 out of range
      do_op(2'd0, 2'd2, 6'd0, 16'h0000, 16'h0, 16'h0);   // R4 wrap to FFFF
      do_op(2'd2, 2'd1, 6'd0, 16'h0, 16'h0, 16'hFFFF);   // R3 wrap to 0
      do_op(2'd1, 2'd3, 6'd63, 16'h0, 16'hFFF0, 16'h0);  // R5 wrap to 0x2F
      do_op(2'd0, 2'd3, 6'd5, 16'h0040, 16'h0, 16'h0);   // R6 disp on X
      do_op(2'd3, 2'd0, 6'd0, 16'h0, 16'h0, 16'h0);      // R6 reserved select

      // R10: req held high during the result cycle is ignored
      @(negedge clk);
      drive(2'd1, 2'd1, 6'd0, 16'h0, 16'h0030, 16'h0);
      req = 1'b1;
      @(negedge clk);
      verify_outputs(2'd1, 2'd1, 6'd0);
      drive(2'd2, 2'd2, 6'd0, 16'h0, 16'h0, 16'h00C0);
      @(negedge clk);
      req = 1'b0;
      check("R10 ignored req no vld", addr_vld, 0);
      check("R10 ignored req no err", req_err, 0);
      check("R10 ignored req addr held", addr, 16'h0030);
      check("R10 ignored req wb held", wb_ptr, 16'h0031);

      for (int i = 0; i < 400; i++) begin
         do_op(2'($urandom), 2'($urandom), 6'($urandom), rnd_ptr(), rnd_ptr(), rnd_ptr());
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule